// File: doc/BRIEF.md
# Byte program pulse-retry controller

This block sits on the host side of a parallel flash device that is driven through a command register. It writes one byte into the array with a closed loop: it applies a timed programming pulse, stops it with a verify command, waits for the write recovery time, and reads the byte back. If the byte read back differs from the data, it starts another attempt. Once the byte matches, or the attempt limit is reached, it returns the device to read mode and reports the result.

A client raises `req_valid` for one cycle with an address and a data byte. The controller then owns the flash bus: chip enable, write strobe, output enable, address and write data, plus the read data coming back. It does not start any bus activity until `vpp_ready` reports that the high programming supply is up. At the end it gives a one-cycle `done`, a `fail` flag and the number of attempts used. The pulse and recovery times are given in nanoseconds and turned into cycle counts from the clock frequency parameter.

Top module: `fpgm_byte_programmer`

## Requirements
- R1: After reset `fl_ce_n`, `fl_we_n` and `fl_oe_n` are high, `fl_dout_en`, `busy` and `done` are low.
- R2: After a request is accepted, `fl_ce_n` stays high for as long as `vpp_ready` has not been seen high.
- R3: Each attempt performs, in order, a write of 40h, a write of the request data to the request address, a write of C0h, and a read of the request address.
- R4: At least PULSE_CYC clock cycles pass between the rising write strobe of the data write and the falling write strobe of the C0h write that follows it.
- R5: At least RECOV_CYC clock cycles pass between the rising write strobe of the C0h write and the falling output enable of the verify read.
- R6: A verify read equal to the request data in all 8 bits ends the loop; `done` then pulses for exactly one cycle with `fail` low and `attempts` equal to the attempts made.
- R7: After MAX_TRIES attempts with no match, `done` pulses with `fail` high and `attempts` equal to MAX_TRIES; `attempts` is never 0 or above MAX_TRIES at `done`.
- R8: After a pass or a fail, a write of 00h is made before `done` is raised.
- R9: The attempt count restarts from zero for each accepted request.
- R10: `fl_we_n` and `fl_oe_n` are never low together, and `fl_ce_n` is low whenever either of them is low.
- R11: A request raised while `busy` is high is ignored: it causes no bus activity at its address and no extra `done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | One-cycle request strobe, taken while idle |
| req_addr | input | AW | Byte address to program |
| req_data | input | 8 | Byte value to program |
| vpp_ready | input | 1 | Programming supply is at its high level |
| busy | output | 1 | A request is being worked on |
| done | output | 1 | One-cycle result strobe |
| fail | output | 1 | Result: limit reached without a match |
| attempts | output | TRY_W | Attempts used for the last request |
| fl_ce_n | output | 1 | Flash chip enable, active low |
| fl_we_n | output | 1 | Flash write strobe, active low |
| fl_oe_n | output | 1 | Flash output enable, active low |
| fl_addr | output | AW | Flash address |
| fl_dout | output | 8 | Data driven toward the flash |
| fl_dout_en | output | 1 | Drive enable for `fl_dout` |
| fl_din | input | 8 | Data read from the flash |

## Verification
The bench builds the block with its default values: a 50 MHz clock, 10 µs and 6 µs giving 500 and 300 cycle windows, a three-cycle strobe and a limit of 25 attempts. With these values a byte that needs exactly 25 pulses and one that would need 26 both finish well inside the run, so the pass at the limit and the first failure are both reached. The flash model only counts a pulse when the window was at least 500 cycles long and flags a verify read inside 300 cycles, so shortened timing shows up as wrong attempt counts.

// File: rtl/fpgm_pkg.sv
package fpgm_pkg;

  localparam logic [7:0] CMD_PGM_SETUP = 8'h40;
  localparam logic [7:0] CMD_PGM_STOP  = 8'hC0;
  localparam logic [7:0] CMD_READ_MODE = 8'h00;

  typedef enum logic [3:0] {
    SQ_IDLE,
    SQ_WAIT_VPP,
    SQ_SETUP,
    SQ_LOAD,
    SQ_PULSE,
    SQ_STOP,
    SQ_RECOV,
    SQ_READ,
    SQ_RESTORE
  } sq_state_t;

  typedef enum logic [1:0] {
    BC_IDLE,
    BC_SETUP,
    BC_STROBE,
    BC_HOLD
  } bc_phase_t;

endpackage

// File: rtl/fpgm_interval_timer.sv
module fpgm_interval_timer #(
  parameter int TW = 10
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic [TW-1:0] count,
  output logic          expired
);

  logic [TW-1:0] remain;

  always_ff @(posedge clk) begin
    if (rst) begin
      remain  <= '0;
      expired <= 1'b0;
    end else begin
      expired <= 1'b0;
      if (load) begin
        remain <= count;
      end else if (remain != '0) begin
        remain <= remain - 1'b1;
        if (remain == TW'(1)) expired <= 1'b1;
      end
    end
  end

endmodule

// File: rtl/fpgm_bus_cycle.sv
module fpgm_bus_cycle
  import fpgm_pkg::*;
#(
  parameter int AW         = 17,
  parameter int STROBE_CYC = 3
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic          is_read,
  input  logic [AW-1:0] addr,
  input  logic [7:0]    wdata,
  output logic [7:0]    rdata,
  output logic          cyc_done,
  output logic          ce_n,
  output logic          we_n,
  output logic          oe_n,
  output logic [AW-1:0] bus_addr,
  output logic [7:0]    bus_dout,
  output logic          bus_drive,
  input  logic [7:0]    bus_din
);

  localparam int SW = (STROBE_CYC < 2) ? 1 : $clog2(STROBE_CYC);

  bc_phase_t     phase;
  logic [SW-1:0] left;
  logic          rd_op;

  always_ff @(posedge clk) begin
    if (rst) begin
      phase     <= BC_IDLE;
      left      <= '0;
      rd_op     <= 1'b0;
      rdata     <= '0;
      cyc_done  <= 1'b0;
      ce_n      <= 1'b1;
      we_n      <= 1'b1;
      oe_n      <= 1'b1;
      bus_addr  <= '0;
      bus_dout  <= '0;
      bus_drive <= 1'b0;
    end else begin
      cyc_done <= 1'b0;
      case (phase)
        BC_IDLE: begin
          if (start) begin
            phase     <= BC_SETUP;
            ce_n      <= 1'b0;
            bus_addr  <= addr;
            bus_dout  <= wdata;
            bus_drive <= !is_read;
            rd_op     <= is_read;
          end
        end
        BC_SETUP: begin
          phase <= BC_STROBE;
          left  <= SW'(STROBE_CYC - 1);
          if (rd_op) oe_n <= 1'b0;
          else       we_n <= 1'b0;
        end
        BC_STROBE: begin
          if (left == '0) begin
            phase <= BC_HOLD;
            we_n  <= 1'b1;
            oe_n  <= 1'b1;
            if (rd_op) rdata <= bus_din;
          end else begin
            left <= left - 1'b1;
          end
        end
        BC_HOLD: begin
          phase     <= BC_IDLE;
          ce_n      <= 1'b1;
          bus_drive <= 1'b0;
          cyc_done  <= 1'b1;
        end
        default: phase <= BC_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/fpgm_sequencer.sv
module fpgm_sequencer
  import fpgm_pkg::*;
#(
  parameter int AW        = 17,
  parameter int MAX_TRIES = 25,
  parameter int TRY_W     = 5,
  parameter int TW        = 10,
  parameter int PULSE_CYC = 500,
  parameter int RECOV_CYC = 300
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             req_valid,
  input  logic [AW-1:0]    req_addr,
  input  logic [7:0]       req_data,
  input  logic             vpp_ready,
  output logic             busy,
  output logic             done,
  output logic             fail,
  output logic [TRY_W-1:0] attempts,
  output logic             bus_start,
  output logic             bus_read,
  output logic [AW-1:0]    bus_addr,
  output logic [7:0]       bus_wdata,
  input  logic             bus_done,
  input  logic [7:0]       bus_rdata,
  output logic             tmr_load,
  output logic [TW-1:0]    tmr_count,
  input  logic             tmr_expired
);

  sq_state_t      state;
  logic [AW-1:0]  tgt_addr;
  logic [7:0]     tgt_data;
  logic           pass;

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= SQ_IDLE;
      busy      <= 1'b0;
      done      <= 1'b0;
      fail      <= 1'b0;
      attempts  <= '0;
      bus_start <= 1'b0;
      bus_read  <= 1'b0;
      bus_addr  <= '0;
      bus_wdata <= '0;
      tmr_load  <= 1'b0;
      tmr_count <= '0;
      tgt_addr  <= '0;
      tgt_data  <= '0;
      pass      <= 1'b0;
    end else begin
      bus_start <= 1'b0;
      tmr_load  <= 1'b0;
      done      <= 1'b0;
      case (state)
        SQ_IDLE: begin
          if (req_valid) begin
            tgt_addr <= req_addr;
            tgt_data <= req_data;
            attempts <= '0;
            fail     <= 1'b0;
            busy     <= 1'b1;
            state    <= SQ_WAIT_VPP;
          end
        end
        SQ_WAIT_VPP: begin
          if (vpp_ready) begin
            bus_start <= 1'b1;
            bus_read  <= 1'b0;
            bus_addr  <= '0;
            bus_wdata <= CMD_PGM_SETUP;
            attempts  <= attempts + 1'b1;
            state     <= SQ_SETUP;
          end
        end
        SQ_SETUP: begin
          if (bus_done) begin
            bus_start <= 1'b1;
            bus_read  <= 1'b0;
            bus_addr  <= tgt_addr;
            bus_wdata <= tgt_data;
            state     <= SQ_LOAD;
          end
        end
        SQ_LOAD: begin
          if (bus_done) begin
            tmr_load  <= 1'b1;
            tmr_count <= TW'(PULSE_CYC);
            state     <= SQ_PULSE;
          end
        end
        SQ_PULSE: begin
          if (tmr_expired) begin
            bus_start <= 1'b1;
            bus_read  <= 1'b0;
            bus_addr  <= '0;
            bus_wdata <= CMD_PGM_STOP;
            state     <= SQ_STOP;
          end
        end
        SQ_STOP: begin
          if (bus_done) begin
            tmr_load  <= 1'b1;
            tmr_count <= TW'(RECOV_CYC);
            state     <= SQ_RECOV;
          end
        end
        SQ_RECOV: begin
          if (tmr_expired) begin
            bus_start <= 1'b1;
            bus_read  <= 1'b1;
            bus_addr  <= tgt_addr;
            bus_wdata <= '0;
            state     <= SQ_READ;
          end
        end
        SQ_READ: begin
          if (bus_done) begin
            bus_start <= 1'b1;
            bus_read  <= 1'b0;
            bus_addr  <= '0;
            if (bus_rdata == tgt_data) begin
              pass      <= 1'b1;
              bus_wdata <= CMD_READ_MODE;
              state     <= SQ_RESTORE;
            end else if (attempts == TRY_W'(MAX_TRIES)) begin
              pass      <= 1'b0;
              bus_wdata <= CMD_READ_MODE;
              state     <= SQ_RESTORE;
            end else begin
              bus_wdata <= CMD_PGM_SETUP;
              attempts  <= attempts + 1'b1;
              state     <= SQ_SETUP;
            end
          end
        end
        SQ_RESTORE: begin
          if (bus_done) begin
            done  <= 1'b1;
            fail  <= !pass;
            busy  <= 1'b0;
            state <= SQ_IDLE;
          end
        end
        default: state <= SQ_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/fpgm_byte_programmer.sv
module fpgm_byte_programmer #(
  parameter int CLK_HZ     = 50_000_000,
  parameter int PULSE_NS   = 10_000,
  parameter int RECOV_NS   = 6_000,
  parameter int MAX_TRIES  = 25,
  parameter int AW         = 17,
  parameter int STROBE_CYC = 3,
  parameter int TRY_W      = $clog2(MAX_TRIES + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             req_valid,
  input  logic [AW-1:0]    req_addr,
  input  logic [7:0]       req_data,
  input  logic             vpp_ready,
  output logic             busy,
  output logic             done,
  output logic             fail,
  output logic [TRY_W-1:0] attempts,
  output logic             fl_ce_n,
  output logic             fl_we_n,
  output logic             fl_oe_n,
  output logic [AW-1:0]    fl_addr,
  output logic [7:0]       fl_dout,
  output logic             fl_dout_en,
  input  logic [7:0]       fl_din
);

  localparam int CLK_KHZ   = CLK_HZ / 1000;
  localparam int PULSE_CYC = (CLK_KHZ * PULSE_NS + 999_999) / 1_000_000;
  localparam int RECOV_CYC = (CLK_KHZ * RECOV_NS + 999_999) / 1_000_000;
  localparam int LONGEST   = (PULSE_CYC > RECOV_CYC) ? PULSE_CYC : RECOV_CYC;
  localparam int TW        = $clog2(LONGEST + 1);

  logic          bus_start, bus_read, bus_done;
  logic [AW-1:0] bus_addr;
  logic [7:0]    bus_wdata, bus_rdata;
  logic          tmr_load, tmr_expired;
  logic [TW-1:0] tmr_count;

  fpgm_sequencer #(
    .AW(AW), .MAX_TRIES(MAX_TRIES), .TRY_W(TRY_W), .TW(TW),
    .PULSE_CYC(PULSE_CYC), .RECOV_CYC(RECOV_CYC)
  ) u_seq (
    .clk(clk), .rst(rst),
    .req_valid(req_valid), .req_addr(req_addr), .req_data(req_data),
    .vpp_ready(vpp_ready),
    .busy(busy), .done(done), .fail(fail), .attempts(attempts),
    .bus_start(bus_start), .bus_read(bus_read), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_done(bus_done), .bus_rdata(bus_rdata),
    .tmr_load(tmr_load), .tmr_count(tmr_count), .tmr_expired(tmr_expired)
  );

  fpgm_interval_timer #(.TW(TW)) u_tmr (
    .clk(clk), .rst(rst), .load(tmr_load), .count(tmr_count),
    .expired(tmr_expired)
  );

  fpgm_bus_cycle #(.AW(AW), .STROBE_CYC(STROBE_CYC)) u_bus (
    .clk(clk), .rst(rst), .start(bus_start), .is_read(bus_read),
    .addr(bus_addr), .wdata(bus_wdata), .rdata(bus_rdata),
    .cyc_done(bus_done),
    .ce_n(fl_ce_n), .we_n(fl_we_n), .oe_n(fl_oe_n),
    .bus_addr(fl_addr), .bus_dout(fl_dout), .bus_drive(fl_dout_en),
    .bus_din(fl_din)
  );

endmodule

// File: rtl/fpgm_byte_programmer_chk.sv
module fpgm_byte_programmer_chk #(
  parameter int MAX_TRIES = 25,
  parameter int TRY_W     = 5,
  parameter int PULSE_CYC = 500,
  parameter int RECOV_CYC = 300
) (
  input logic             clk,
  input logic             rst,
  input logic             vpp_ready,
  input logic             busy,
  input logic             done,
  input logic             fail,
  input logic [TRY_W-1:0] attempts,
  input logic             fl_ce_n,
  input logic             fl_we_n,
  input logic             fl_oe_n,
  input logic [7:0]       fl_dout
);

  logic        we_q, oe_q, seen_vpp;
  logic [1:0]  ph;
  logic [31:0] gap;

  always_ff @(posedge clk) begin
    if (rst) begin
      we_q     <= 1'b1;
      oe_q     <= 1'b1;
      seen_vpp <= 1'b0;
      ph       <= 2'd0;
      gap      <= '0;
    end else begin
      we_q <= fl_we_n;
      oe_q <= fl_oe_n;
      if (!busy)          seen_vpp <= 1'b0;
      else if (vpp_ready) seen_vpp <= 1'b1;
      if (gap != '1) gap <= gap + 1'b1;
      case (ph)
        2'd0: if (fl_we_n && !we_q && fl_dout == 8'h40) ph <= 2'd1;
        2'd1: if (fl_we_n && !we_q) begin ph <= 2'd2; gap <= '0; end
        2'd2: if (fl_we_n && !we_q) begin ph <= 2'd3; gap <= '0; end
        default: if (!fl_oe_n && oe_q) ph <= 2'd0;
      endcase
    end
  end

  assert_strobe_excl_R10: assert property (@(posedge clk) disable iff (rst)
    !(!fl_we_n && !fl_oe_n));

  assert_ce_with_strobe_R10: assert property (@(posedge clk) disable iff (rst)
    (!fl_we_n || !fl_oe_n) |-> !fl_ce_n);

  assert_vpp_gate_R2: assert property (@(posedge clk) disable iff (rst)
    (busy && !seen_vpp && !vpp_ready) |-> fl_ce_n);

  assert_pulse_window_R4: assert property (@(posedge clk) disable iff (rst)
    (ph == 2'd2 && !fl_we_n && we_q) |-> (gap >= PULSE_CYC));

  assert_recovery_window_R5: assert property (@(posedge clk) disable iff (rst)
    (ph == 2'd3 && !fl_oe_n && oe_q) |-> (gap >= RECOV_CYC));

  assert_done_single_R6: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  assert_attempt_range_R7: assert property (@(posedge clk) disable iff (rst)
    done |-> (attempts != '0 && attempts <= TRY_W'(MAX_TRIES)));

  assert_fail_at_limit_R7: assert property (@(posedge clk) disable iff (rst)
    (done && fail) |-> (attempts == TRY_W'(MAX_TRIES)));

  assert_attempts_clear_R9: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> (attempts == '0));

endmodule

bind fpgm_byte_programmer fpgm_byte_programmer_chk #(
  .MAX_TRIES(MAX_TRIES), .TRY_W(TRY_W),
  .PULSE_CYC(PULSE_CYC), .RECOV_CYC(RECOV_CYC)
) u_chk (
  .clk(clk), .rst(rst), .vpp_ready(vpp_ready), .busy(busy), .done(done),
  .fail(fail), .attempts(attempts), .fl_ce_n(fl_ce_n), .fl_we_n(fl_we_n),
  .fl_oe_n(fl_oe_n), .fl_dout(fl_dout)
);

// File: tb/fpgm_byte_programmer_bench.sv
module fpgm_byte_programmer_bench;

  localparam int AW    = 17;
  localparam int TRY_W = 5;
  localparam int LIMIT = 25;
  localparam int PULSE_MIN = 500;  // 10 us at 50 MHz
  localparam int RECOV_MIN = 300;  // 6 us at 50 MHz

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic             req_valid = 1'b0;
  logic [AW-1:0]    req_addr = '0;
  logic [7:0]       req_data = '0;
  logic             vpp_ready = 1'b0;
  logic             busy, done, fail;
  logic [TRY_W-1:0] attempts;
  logic             fl_ce_n, fl_we_n, fl_oe_n, fl_dout_en;
  logic [AW-1:0]    fl_addr;
  logic [7:0]       fl_dout;
  logic [7:0]       fl_din = 8'hFF;

  always #10 clk = ~clk;

  fpgm_byte_programmer u_fpgm_byte_programmer (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_addr(req_addr),
    .req_data(req_data), .vpp_ready(vpp_ready), .busy(busy), .done(done),
    .fail(fail), .attempts(attempts), .fl_ce_n(fl_ce_n), .fl_we_n(fl_we_n),
    .fl_oe_n(fl_oe_n), .fl_addr(fl_addr), .fl_dout(fl_dout),
    .fl_dout_en(fl_dout_en), .fl_din(fl_din)
  );

  int n_cmp = 0;
  int n_bad = 0;
  bit finished = 0;

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // ---------------- flash model ----------------
  int            cyc = 0;
  int            mode = 0;   // 0 read, 1 setup seen, 2 pulsing, 3 verify
  logic [AW-1:0] lat_addr = '0;
  logic [AW-1:0] exp_addr = '0;
  logic [7:0]    exp_data = '0;
  int            need_pulses = 1;
  int            pulses = 0;
  int            proto_err = 0;
  int            t_data = 0, t_wfall = 0, t_c0 = 0;
  bit            saw_restore = 0;
  bit            strobe_err = 0;
  bit            vpp_err = 0;
  logic          we_p = 1'b1, oe_p = 1'b1;

  always @(negedge clk) begin
    cyc++;
    if (!rst) begin
      if (!fl_we_n && !fl_oe_n) strobe_err = 1;
      if ((!fl_we_n || !fl_oe_n) && fl_ce_n) strobe_err = 1;
      if (!fl_ce_n && !vpp_ready) vpp_err = 1;
      if (!fl_we_n && we_p) begin
        lat_addr = fl_addr;
        t_wfall  = cyc;
      end
      if (fl_we_n && !we_p) begin
        case (mode)
          1: begin
            if (lat_addr != exp_addr || fl_dout != exp_data) proto_err++;
            mode = 2; t_data = cyc;
          end
          2: begin
            if (fl_dout != 8'hC0) proto_err++;
            else begin
              if (t_wfall - t_data >= PULSE_MIN) pulses++;
              else proto_err++;
            end
            mode = 3; t_c0 = cyc;
          end
          default: begin
            if (fl_dout == 8'h40) mode = 1;
            else if (fl_dout == 8'h00) begin
              if (mode == 3) saw_restore = 1;
              mode = 0;
            end else proto_err++;
          end
        endcase
      end
      if (!fl_oe_n && oe_p) begin
        if (mode == 3) begin
          if (cyc - t_c0 < RECOV_MIN) proto_err++;
          if (fl_addr != exp_addr) proto_err++;
        end else proto_err++;
      end
      we_p = fl_we_n;
      oe_p = fl_oe_n;
    end
    if (mode == 3) fl_din <= (pulses >= need_pulses) ? exp_data : (exp_data ^ 8'h5A);
    else           fl_din <= 8'hFF;
  end

  // ---------------- scoreboard ----------------
  typedef struct packed { bit f; int unsigned n; } res_t;
  res_t exp_q[$];
  int   done_seen = 0;

  always @(negedge clk) begin
    if (!rst && done) begin
      done_seen++;
      if (exp_q.size() == 0) begin
        check(0, "R11", "unexpected done", 1, 0);
      end else begin
        res_t e;
        e = exp_q.pop_front();
        check(fail == e.f, e.f ? "R7" : "R6", "fail flag", int'(fail), int'(e.f));
        check(int'(attempts) == int'(e.n), e.f ? "R7" : "R6", "attempts",
              int'(attempts), int'(e.n));
        check(saw_restore, "R8", "read-mode write before done", int'(saw_restore), 1);
      end
    end
  end

  task automatic run_byte(input logic [AW-1:0] a, input logic [7:0] d,
                          input int need, input bit poke_busy);
    res_t e;
    int start;
    exp_addr = a; exp_data = d; need_pulses = need;
    pulses = 0; proto_err = 0; saw_restore = 0;
    e.f = (need > LIMIT);
    e.n = (need > LIMIT) ? LIMIT : need;
    exp_q.push_back(e);
    start = done_seen;
    @(negedge clk);
    req_valid = 1; req_addr = a; req_data = d;
    @(negedge clk);
    req_valid = 0;
    if (poke_busy) begin
      repeat (40) @(negedge clk);
      req_valid = 1; req_addr = a ^ 17'h155; req_data = ~d;
      @(negedge clk);
      req_valid = 0;
    end
    while (done_seen == start) @(negedge clk);
    repeat (3) @(negedge clk);
    check(proto_err == 0, "R3", "sequence/timing errors (R4 R5)", proto_err, 0);
    check(busy == 0, "R6", "busy after done", int'(busy), 0);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R1: idle levels after reset
    check(fl_ce_n && fl_we_n && fl_oe_n, "R1", "strobes high", int'({fl_ce_n, fl_we_n, fl_oe_n}), 7);
    check(!busy && !done, "R1", "busy/done low", int'({busy, done}), 0);
    check(!fl_dout_en, "R1", "drive off", int'(fl_dout_en), 0);

    // R2: supply not ready, request must wait
    exp_addr = 17'h00123; exp_data = 8'hA5; need_pulses = 1;
    pulses = 0; proto_err = 0; saw_restore = 0;
    begin
      res_t e;
      e.f = 0; e.n = 1;
      exp_q.push_back(e);
    end
    @(negedge clk);
    req_valid = 1; req_addr = 17'h00123; req_data = 8'hA5;
    @(negedge clk);
    req_valid = 0;
    repeat (60) @(negedge clk);
    check(fl_ce_n == 1 && !vpp_err, "R2", "bus quiet without supply", int'(vpp_err), 0);
    check(busy == 1, "R2", "request held", int'(busy), 1);
    vpp_ready = 1;
    while (done_seen == 0) @(negedge clk);
    repeat (3) @(negedge clk);
    check(proto_err == 0, "R3", "first byte sequence", proto_err, 0);

    run_byte(17'h1FFFF, 8'h00, 3, 0);       // R6 with retries
    run_byte(17'h00001, 8'hFF, 25, 0);      // R7 boundary: pass on last attempt
    run_byte(17'h0ABCD, 8'h3C, 26, 0);      // R7: limit reached, fail
    run_byte(17'h00777, 8'h81, 1, 0);       // R9: count restarts after fail
    run_byte(17'h04000, 8'h5A, 2, 1);       // R11: request while busy ignored
    repeat (40) @(negedge clk);
    check(busy == 0, "R11", "no extra job started", int'(busy), 0);
    check(exp_q.size() == 0, "R11", "pending results", exp_q.size(), 0);
    check(!strobe_err, "R10", "strobe overlap seen", int'(strobe_err), 0);
    check(!vpp_err, "R2", "bus use without supply", int'(vpp_err), 0);

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (180000) @(posedge clk);
    if (!finished) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

endmodule